// File: doc/BRIEF.md
# Standby Bus Wake-Up Filter

This block sits behind the low-power activity detector of a bus transceiver and turns its raw dominant/recessive sample into a clean, active-low wake-up indication while the transceiver rests in standby. The raw sample is first synchronized to the local clock. It then passes through a symmetric persistence filter. A bus level reaches the output only after it has held for a programmable number of clock cycles. The filter never latches, so a bus that falls quiet again releases the wake request by itself.

A second timer guards against a bus that is stuck dominant, for example after a short circuit or a failed node. The timer measures each filtered dominant period. When a period runs past a programmable limit, the wake request is withdrawn. The request stays withdrawn until the filtered bus has been recessive again and a fresh dominant period begins. Outside standby the filter and timer are cleared and the output rests inactive. Mode control and the normal-mode receive path are handled elsewhere.

Top module: `stby_wake_filter`

## Requirements
- R1: While reset is asserted, and after reset until a filtered dominant level exists, `wakeReqN` is 1 (no wake request), even if `busDomRaw` is 1 during reset.
- R2: With `standbyEn`=1, `busDomRaw`=1 means dominant. When `busDomRaw` rises and holds, `wakeReqN` is still 1 after FILT_CYCLES+2 rising clock edges and is 0 after FILT_CYCLES+3 edges. That count is two synchronizer stages, FILT_CYCLES filter cycles and one output register.
- R3: A dominant pulse lasting fewer than FILT_CYCLES cycles leaves `wakeReqN` at 1 throughout. A dominant pulse of W ≥ FILT_CYCLES cycles (W < TMO_CYCLES) gives exactly W cycles of `wakeReqN`=0.
- R4: The filter does not latch. After the bus turns recessive (`busDomRaw`=0) and holds, `wakeReqN` is still 0 after FILT_CYCLES+2 edges and returns to 1 after FILT_CYCLES+3 edges.
- R5: A recessive glitch shorter than FILT_CYCLES cycles during an active wake request leaves `wakeReqN` at 0.
- R6: If the filtered bus stays dominant, `wakeReqN` returns to 1 exactly TMO_CYCLES cycles after it went to 0.
- R7: The dominant timer restarts at every filtered recessive-to-dominant transition. Dominant periods each shorter than TMO_CYCLES, separated by filtered recessive gaps, are never cut short.
- R8: After a time-out, `wakeReqN` stays 1 while the bus stays dominant, including across recessive glitches shorter than FILT_CYCLES. A new wake request needs a filtered recessive period followed by a new filtered dominant period.
- R9: When `standbyEn` is 0, `wakeReqN` is 1 from the next clock edge onward, and the filter and timer clear. On re-entry with the bus already dominant, `wakeReqN` is 1 after FILT_CYCLES edges and 0 after FILT_CYCLES+1 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| standbyEn | input | 1 | 1 while the transceiver is in standby; enables filtering |
| busDomRaw | input | 1 | Raw, unsynchronized bus sample from the low-power detector, 1 = dominant |
| wakeReqN | output | 1 | Wake-up indication, 0 = wake request, 1 = none |

## Verification
Assertions check four things on every cycle. The filtered level only ever moves to the value the synchronizer held on the cycle before. The time-out only exists right after a filtered dominant cycle. A time-out or standby exit forces the output inactive on the next cycle. A wake request can only start from a filtered dominant level in standby. The exact edge counts of filter and output latency can only be shown by the bench's scenarios. So can the rejection of pulses one cycle short of the limit, the timer restart between separated dominant periods, the hold-off after a clamp, and the full filter delay on re-entering standby.

// File: rtl/wkf_pkg.sv
package wkf_pkg;

  // Control states of the wake indicator.
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,  // not in standby, output inactive
    ST_LISTEN  = 2'd1,  // standby, no filtered dominant yet
    ST_WAKE    = 2'd2,  // filtered dominant, wake request driven
    ST_CLAMPED = 2'd3   // dominant exceeded the time-out, request withdrawn
  } wkfState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clrFilt;   // clear filter counter and filtered level
    logic clrTimer;  // clear dominant-duration timer
    logic cntEn;     // let filter and timer advance
  } wkfStrobe_t;

endpackage

// File: rtl/wkf_datapath.sv
module wkf_datapath
  import wkf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 50,
  parameter int TMO_CYCLES  = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busDomRaw,
  input  wkfStrobe_t ctl,
  output logic       filtDom,
  output logic       tmo
);

  localparam int FW = $clog2(FILT_CYCLES + 1);
  localparam int TW = $clog2(TMO_CYCLES + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   busSync;
  logic [FW-1:0]          fltCnt;
  logic                   filtQ;
  logic [TW-1:0]          domCnt;

  // Synchronizer chain; one stage or a shift chain picked by parameter.
  if (SYNC_STAGES == 1) begin : g_sync1
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= busDomRaw;
    end
  end else begin : g_syncN
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= {syncQ[SYNC_STAGES-2:0], busDomRaw};
    end
  end

  assign busSync = syncQ[SYNC_STAGES-1];

  // Symmetric persistence filter: flip only after FILT_CYCLES disagreeing samples.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtQ  <= 1'b0;
      fltCnt <= '0;
    end else if (ctl.clrFilt) begin
      filtQ  <= 1'b0;
      fltCnt <= '0;
    end else if (ctl.cntEn) begin
      if (busSync != filtQ) begin
        if (fltCnt == FW'(FILT_CYCLES - 1)) begin
          filtQ  <= busSync;
          fltCnt <= '0;
        end else begin
          fltCnt <= fltCnt + 1'b1;
        end
      end else begin
        fltCnt <= '0;
      end
    end
  end

  // Dominant-duration timer, saturating at the limit, cleared by recessive.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      domCnt <= '0;
    end else if (ctl.clrTimer) begin
      domCnt <= '0;
    end else if (ctl.cntEn) begin
      if (!filtQ)                          domCnt <= '0;
      else if (domCnt != TW'(TMO_CYCLES))  domCnt <= domCnt + 1'b1;
    end
  end

  assign filtDom = filtQ;
  assign tmo     = (domCnt == TW'(TMO_CYCLES));

  // R3
  filt_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((filtQ != $past(filtQ)) && !$past(ctl.clrFilt)) |-> (filtQ == $past(busSync)));

  // R3
  filt_cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fltCnt < FW'(FILT_CYCLES)));

  // R7
  tmo_after_dom_chk: assert property (@(posedge clk) disable iff (!rstN)
    tmo |-> $past(filtQ));

endmodule

// File: rtl/wkf_control.sv
module wkf_control
  import wkf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       standbyEn,
  input  logic       filtDom,
  input  logic       tmo,
  output wkfStrobe_t ctl,
  output logic       wakeReqN
);

  wkfState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    if (!standbyEn) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:    stateNxt = ST_LISTEN;
        ST_LISTEN:  if (filtDom && !tmo) stateNxt = ST_WAKE;
        ST_WAKE:    if (tmo)             stateNxt = ST_CLAMPED;
                    else if (!filtDom)   stateNxt = ST_LISTEN;
        ST_CLAMPED: if (!filtDom)        stateNxt = ST_LISTEN;
        default:                         stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  // Strobes follow the mode input directly so the datapath clears in the same cycle.
  always_comb begin
    ctl.clrFilt  = !standbyEn;
    ctl.clrTimer = !standbyEn;
    ctl.cntEn    = standbyEn;
  end

  assign wakeReqN = (state != ST_WAKE);

  // R9
  standby_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !standbyEn |=> wakeReqN);

  // R6
  tmo_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    tmo |=> wakeReqN);

  // R8
  clamp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_CLAMPED) && filtDom && standbyEn) |=> wakeReqN);

  // R2
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wakeReqN) |-> ($past(filtDom) && $past(standbyEn)));

endmodule

// File: rtl/stby_wake_filter.sv
module stby_wake_filter
  import wkf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 50,
  parameter int TMO_CYCLES  = 100000
) (
  input  logic clk,
  input  logic rstN,
  input  logic standbyEn,
  input  logic busDomRaw,
  output logic wakeReqN
);

  wkfStrobe_t ctl;
  logic       filtDom;
  logic       tmo;

  wkf_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_CYCLES(FILT_CYCLES),
    .TMO_CYCLES (TMO_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busDomRaw(busDomRaw),
    .ctl      (ctl),
    .filtDom  (filtDom),
    .tmo      (tmo)
  );

  wkf_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .standbyEn(standbyEn),
    .filtDom  (filtDom),
    .tmo      (tmo),
    .ctl      (ctl),
    .wakeReqN (wakeReqN)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rstN |-> wakeReqN);

endmodule

// File: tb/stby_wake_filter_tb.sv
module stby_wake_filter_tb;

  localparam int FILT = 8;
  localparam int TMO  = 60;
  localparam int NVEC = 9;

  // Dominant pulse width and expected number of low output cycles.
  localparam int vecW  [NVEC] = '{1, 7, 8, 9, 25, 59, 60, 75, 200};
  localparam int vecLow[NVEC] = '{0, 0, 8, 9, 25, 59, 60, 60, 60};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic standbyEn = 1'b0;
  logic busDomRaw = 1'b0;
  logic wakeReqN;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stby_wake_filter #(
    .SYNC_STAGES(2),
    .FILT_CYCLES(FILT),
    .TMO_CYCLES (TMO)
  ) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .standbyEn(standbyEn),
    .busDomRaw(busDomRaw),
    .wakeReqN (wakeReqN)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance n edges, sampling after each at the falling edge; counts low samples.
  task automatic run(input int n, output int lowCnt);
    lowCnt = 0;
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      if (!wakeReqN) lowCnt++;
    end
  endtask

  function automatic string tagOf(input int w);
    if (w < FILT) return "R3";
    if (w < TMO)  return "R2";
    return "R6";
  endfunction

  initial begin
    int a, b, c, d, e;
    // R1: reset with dominant bus
    standbyEn = 1'b1;
    busDomRaw = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 during reset", wakeReqN, 1);
    busDomRaw = 1'b0;
    rstN = 1'b1;
    run(20, a);
    check("R1 after reset", a, 0);
    check("R1 after reset level", wakeReqN, 1);

    // Vector table: dominant pulse, then recessive settle
    for (int i = 0; i < NVEC; i++) begin
      busDomRaw = 1'b1;
      run(vecW[i], a);
      busDomRaw = 1'b0;
      run(40, b);
      check(tagOf(vecW[i]), a + b, vecLow[i]);
      check("R4 released", wakeReqN, 1);
    end

    // R2: exact assertion latency
    busDomRaw = 1'b1;
    run(FILT + 2, a);
    check("R2 before latency", wakeReqN, 1);
    run(1, a);
    check("R2 at latency", wakeReqN, 0);

    // R5: short recessive glitch during wake
    busDomRaw = 1'b0;
    run(FILT - 1, a);
    busDomRaw = 1'b1;
    run(20, b);
    check("R5 glitch ignored", a + b, FILT - 1 + 20);

    // R4: exact release latency
    busDomRaw = 1'b0;
    run(FILT + 2, a);
    check("R4 before latency", wakeReqN, 0);
    run(1, a);
    check("R4 at latency", wakeReqN, 1);
    run(20, a);

    // R7: two dominant periods separated by a filtered recessive gap
    busDomRaw = 1'b1; run(40, a);
    busDomRaw = 1'b0; run(20, b);
    busDomRaw = 1'b1; run(40, c);
    busDomRaw = 1'b0; run(40, d);
    check("R7 timer restart", a + b + c + d, 80);

    // R6/R8: clamp, glitch, continued dominant
    busDomRaw = 1'b1; run(100, a);
    check("R6 clamp low time", a, TMO);
    busDomRaw = 1'b0; run(FILT - 1, b);
    busDomRaw = 1'b1; run(50, c);
    check("R8 held off after clamp", b + c, 0);
    busDomRaw = 1'b0; run(20, d);
    check("R8 recessive after clamp", d, 0);
    busDomRaw = 1'b1; run(20, e);
    check("R8 new wake", e, 20 - FILT - 2);
    busDomRaw = 1'b0; run(40, a);

    // R9: leaving and re-entering standby
    busDomRaw = 1'b1; run(30, a);
    check("R9 wake before exit", wakeReqN, 0);
    standbyEn = 1'b0; run(1, a);
    check("R9 exit next edge", wakeReqN, 1);
    run(200, b);
    check("R9 idle ignores bus", b, 0);
    standbyEn = 1'b1; run(FILT, c);
    check("R9 re-entry full filter", c, 0);
    run(1, d);
    check("R9 re-entry wake", wakeReqN, 0);
    busDomRaw = 1'b0; run(40, a);
    check("R4 final release", wakeReqN, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule